// File: doc/BRIEF.md
# Priority Interrupt Controller

The controller gathers eight maskable interrupt request lines and one non-maskable line. It decides which pending request goes to the processor and runs the acknowledge handshake. Each maskable line has its own enable bit and its own capture mode. A line in level mode is pending while its last clock sample is high. A line in edge mode latches a rising edge and holds it until the request is acknowledged. The non-maskable line always captures on edges.

Software sets the enables, the capture modes and the arbitration scheme through three whole-word write strobes, at any time. There are three schemes. Fixed priority favours the lowest-numbered line. Latest arrival favours the line that rose most recently. Rotating priority hands the top slot to the line after the one whose service just ended. The processor pulses `ack_i` to take the presented request, reads its vector on `vec_o` and pulses `eoi_i` when the handler finishes. `in_service_o` shows which requests are being serviced. While a request is in service, requests of lower priority stay hidden.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every line is disabled and in level mode, and the scheme is fixed priority. No request is pending or in service, `irq_o` is low and `vec_o` equals N+1 (9). A disabled line never raises `irq_o`.
- R2: A line whose capture bit is 1 (edge mode) latches a rising edge seen between two clock samples. `irq_o` rises in the cycle after that sample. The request stays pending after the line falls, until it is acknowledged.
- R3: A line whose capture bit is 0 (level mode) is pending only while its most recent clock sample is high. When the line drops, the request disappears without any acknowledge. A pulse that starts and ends between two clock edges is never recorded.
- R4: If a level-mode line is still high when its service ends, it is presented again as a new request.
- R5: Mode code 00 selects fixed priority, and the reserved code 11 behaves the same. Line i has priority level i+1, where level 1 is the highest, and its vector is i+1. The pending, enabled line with the lowest number wins.
- R6: In fixed and rotating modes, a line in service masks itself and every line of lower priority. A pending line of higher priority still raises `irq_o` and can be acknowledged on top of the current service (nesting).
- R7: The non-maskable line latches rising edges whatever the enable bits hold. It wins over every maskable line, its vector is 0, and its in-service flag is `in_service_o[8]`. While that flag is set, no request is presented.
- R8: Mode code 01 selects latest arrival. The line that rose most recently wins if it is eligible; when several lines rise at once, the lowest-numbered one counts as most recent. Otherwise the lowest-numbered eligible line wins. Any maskable line in service masks all maskable lines.
- R9: Mode code 10 selects rotating priority. Line 0 is highest after reset. When service of line k ends, line k+1 (mod 8) becomes highest and line k becomes lowest.
- R10: The enable word can be rewritten at any time. A disabled line's edge latch is kept, and its request is presented once the line is enabled again.
- R11: An `ack_i` pulse while `irq_o` is high does three things in the next cycle. `vec_o` shows the winner's vector, that request's in-service bit is set, and its edge latch is cleared. An `ack_i` pulse while `irq_o` is low sets `vec_o` to 9 and changes nothing else.
- R12: An `eoi_i` pulse clears the in-service bit of highest priority, with the non-maskable flag cleared first. With nothing in service, `eoi_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N (8) | Maskable request lines |
| nmi_i | input | 1 | Non-maskable request line |
| en_we_i | input | 1 | Write strobe for the enable word |
| en_wdata_i | input | N (8) | Enable word, 1 = line enabled |
| trig_we_i | input | 1 | Write strobe for the capture-mode word |
| trig_wdata_i | input | N (8) | Capture mode, 1 = edge, 0 = level |
| mode_we_i | input | 1 | Write strobe for the arbitration mode |
| mode_wdata_i | input | 2 | 00 fixed, 01 latest arrival, 10 rotating, 11 fixed |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| eoi_i | input | 1 | End-of-service pulse |
| irq_o | output | 1 | Request to the processor |
| vec_o | output | 4 | Vector of the last acknowledge: 0 non-maskable, i+1 for line i, 9 spurious |
| in_service_o | output | N+1 (9) | In-service flags; bit 8 is the non-maskable line |

## Verification
The checker watches the handshake on every cycle. An acknowledge that finds a request adds exactly one in-service bit. One that finds none yields the spurious vector and leaves the in-service flags unchanged. An end-of-service pulse removes exactly one bit. Non-maskable service silences every other request. Arbitration order in each scheme, level against edge capture, the re-presentation of a level line at end of service, latching across disable periods and rotation after each service can only be shown by the bench's scenarios, checked against its own cycle model on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED  = 2'b00,
    MODE_LATEST = 2'b01,
    MODE_ROTATE = 2'b10
  } pic_mode_e;
endpackage

// File: rtl/pic_capture.sv
module pic_capture #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic prev_q, lat_q;
    assign rise_o[g] = irq_i[g] & ~prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= irq_i[g];
        // a fresh edge wins over a same-cycle clear
        lat_q  <= (rise_o[g] & edge_i[g]) | (lat_q & ~clr_i[g]);
      end
    end
    assign pend_o[g] = edge_i[g] ? lat_q : prev_q;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter import pic_pkg::*; #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int LW = 4
) (
  input  pic_mode_e     mode_i,
  input  logic [IW-1:0] ptr_i,
  input  logic [LW-1:0] last_i,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  isr_i,
  input  logic          nmi_pend_i,
  input  logic          nmi_isr_i,
  output logic          req_o,
  output logic          sel_nmi_o,
  output logic [IW-1:0] sel_idx_o,
  output logic          eoi_any_o,
  output logic [IW-1:0] eoi_idx_o
);
  int         rank_w [N];
  logic [N-1:0] cand_w;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (mode_i == MODE_ROTATE)      rank_w[i] = (i + N - int'(ptr_i)) % N;
      else if (mode_i == MODE_LATEST) rank_w[i] = 0;
      else                            rank_w[i] = i;
    end
  end

  always_comb begin
    int floor_r;
    int best_r;
    logic any_c;
    floor_r   = N;
    eoi_any_o = 1'b0;
    eoi_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (isr_i[i] && rank_w[i] < floor_r) begin
        floor_r   = rank_w[i];
        eoi_any_o = 1'b1;
        eoi_idx_o = IW'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      cand_w[i] = pend_i[i] & en_i[i] & ~isr_i[i] & ~nmi_isr_i & (rank_w[i] < floor_r);
    end
    best_r    = N;
    any_c     = 1'b0;
    sel_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_w[i] && rank_w[i] < best_r) begin
        best_r    = rank_w[i];
        any_c     = 1'b1;
        sel_idx_o = IW'(i);
      end
    end
    if (mode_i == MODE_LATEST && last_i < LW'(N) && cand_w[last_i[IW-1:0]])
      sel_idx_o = last_i[IW-1:0];
    sel_nmi_o = nmi_pend_i & ~nmi_isr_i;
    req_o     = sel_nmi_o | any_c;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import pic_pkg::*; #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int LW = $clog2(N + 1),
  localparam int VW = $clog2(N + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          nmi_i,
  input  logic          en_we_i,
  input  logic [N-1:0]  en_wdata_i,
  input  logic          trig_we_i,
  input  logic [N-1:0]  trig_wdata_i,
  input  logic          mode_we_i,
  input  logic [1:0]    mode_wdata_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic [N:0]    in_service_o
);
  localparam logic [VW-1:0] VEC_SPUR = VW'(N + 1);

  logic [N-1:0]  en_q, trig_q, isr_q, isr_d, ack_clr;
  logic [N:0]    pend_all, rise_all;
  logic          nmi_isr_q, nmi_isr_d, nmi_clr;
  pic_mode_e     mode_q, mode_dec;
  logic [IW-1:0] ptr_q, ptr_nx, sel_idx, eoi_idx;
  logic [LW-1:0] last_q, newest;
  logic          req, sel_nmi, eoi_any, ack_fire, rot_step;
  logic [VW-1:0] vec_q, ack_vec;

  pic_capture #(.N(N + 1)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  ({nmi_i, irq_i}),
    .edge_i ({1'b1, trig_q}),
    .clr_i  ({nmi_clr, ack_clr}),
    .pend_o (pend_all),
    .rise_o (rise_all)
  );

  pic_arbiter #(.N(N), .IW(IW), .LW(LW)) u_arb (
    .mode_i     (mode_q),
    .ptr_i      (ptr_q),
    .last_i     (last_q),
    .pend_i     (pend_all[N-1:0]),
    .en_i       (en_q),
    .isr_i      (isr_q),
    .nmi_pend_i (pend_all[N]),
    .nmi_isr_i  (nmi_isr_q),
    .req_o      (req),
    .sel_nmi_o  (sel_nmi),
    .sel_idx_o  (sel_idx),
    .eoi_any_o  (eoi_any),
    .eoi_idx_o  (eoi_idx)
  );

  always_comb begin
    unique case (mode_wdata_i)
      2'b01:   mode_dec = MODE_LATEST;
      2'b10:   mode_dec = MODE_ROTATE;
      default: mode_dec = MODE_FIXED;
    endcase
  end

  // lowest index among simultaneous rises; index N marks the non-maskable line
  always_comb begin
    newest = '0;
    for (int i = N; i >= 0; i--) begin
      if (rise_all[i]) newest = LW'(i);
    end
  end

  assign ack_fire = ack_i & req;
  assign nmi_clr  = ack_fire & sel_nmi;
  assign ack_clr  = (ack_fire && !sel_nmi) ? (N'(1) << sel_idx) : '0;
  assign ack_vec  = sel_nmi ? '0 : VW'(sel_idx) + VW'(1);
  assign rot_step = eoi_i & ~nmi_isr_q & eoi_any & (mode_q == MODE_ROTATE);
  assign ptr_nx   = (eoi_idx == IW'(N - 1)) ? '0 : eoi_idx + IW'(1);

  always_comb begin
    isr_d     = isr_q;
    nmi_isr_d = nmi_isr_q;
    if (eoi_i) begin
      if (nmi_isr_q)    nmi_isr_d = 1'b0;
      else if (eoi_any) isr_d[eoi_idx] = 1'b0;
    end
    isr_d     = isr_d | ack_clr;
    nmi_isr_d = nmi_isr_d | nmi_clr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      trig_q    <= '0;
      mode_q    <= MODE_FIXED;
      ptr_q     <= '0;
      last_q    <= '0;
      isr_q     <= '0;
      nmi_isr_q <= 1'b0;
      vec_q     <= VEC_SPUR;
    end else begin
      if (en_we_i)   en_q   <= en_wdata_i;
      if (trig_we_i) trig_q <= trig_wdata_i;
      if (mode_we_i) mode_q <= mode_dec;
      if (|rise_all) last_q <= newest;
      if (rot_step)  ptr_q  <= ptr_nx;
      isr_q     <= isr_d;
      nmi_isr_q <= nmi_isr_d;
      if (ack_i) vec_q <= ack_fire ? ack_vec : VEC_SPUR;
    end
  end

  assign irq_o        = req;
  assign vec_o        = vec_q;
  assign in_service_o = {nmi_isr_q, isr_q};
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N  = 8,
  parameter int VW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          eoi_i,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic [N:0]    in_service_o
);
  p_ack_adds_one_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o && !eoi_i |=> $countones(in_service_o) == $past($countones(in_service_o)) + 1);

  p_spurious_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !irq_o && !eoi_i |=> vec_o == VW'(N + 1) && $stable(in_service_o));

  p_eoi_drops_one_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && !ack_i && (|in_service_o) |=> $countones(in_service_o) == $past($countones(in_service_o)) - 1);

  p_nmi_service_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_service_o[N] |-> !irq_o);

  p_nmi_ack_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && in_service_o[N] |=> vec_o == VW'(N + 1));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N), .VW(VW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_i        (ack_i),
  .eoi_i        (eoi_i),
  .irq_o        (irq_o),
  .vec_o        (vec_o),
  .in_service_o (in_service_o)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       nmi = 1'b0;
  logic       en_we = 1'b0, trig_we = 1'b0, mode_we = 1'b0;
  logic [7:0] en_wd = '0, trig_wd = '0;
  logic [1:0] mode_wd = '0;
  logic       ack = 1'b0, eoi = 1'b0;
  logic       irq_o;
  logic [3:0] vec_o;
  logic [8:0] isr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi),
    .en_we_i(en_we), .en_wdata_i(en_wd), .trig_we_i(trig_we), .trig_wdata_i(trig_wd),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wd), .ack_i(ack), .eoi_i(eoi),
    .irq_o(irq_o), .vec_o(vec_o), .in_service_o(isr_o)
  );

  // ---------------- behavioural reference ----------------
  bit m_en [N], m_trig [N];
  bit m_prev [N+1], m_lat [N+1], m_isr [N+1];
  int m_mode, m_top, m_last, m_vec;

  function automatic bit m_pend(int i);
    return m_trig[i] ? m_lat[i] : m_prev[i];
  endfunction

  function automatic void m_order(ref int q[$]);
    int base;
    q.delete();
    base = (m_mode == 2) ? m_top : 0;
    for (int j = 0; j < N; j++) q.push_back((base + j) % N);
  endfunction

  function automatic int m_select();
    int q[$];
    if (m_lat[N] && !m_isr[N]) return N;
    if (m_isr[N]) return -1;
    if (m_mode == 1) begin
      for (int i = 0; i < N; i++) if (m_isr[i]) return -1;
      if (m_last < N && m_pend(m_last) && m_en[m_last]) return m_last;
      for (int i = 0; i < N; i++) if (m_pend(i) && m_en[i]) return i;
      return -1;
    end
    m_order(q);
    foreach (q[k]) begin
      if (m_isr[q[k]]) return -1;
      if (m_pend(q[k]) && m_en[q[k]]) return q[k];
    end
    return -1;
  endfunction

  function automatic int m_eoi_target();
    int q[$];
    if (m_isr[N]) return N;
    if (m_mode == 1) begin
      for (int i = 0; i < N; i++) if (m_isr[i]) return i;
      return -1;
    end
    m_order(q);
    foreach (q[k]) if (m_isr[q[k]]) return q[k];
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= N; i++) begin
        m_prev[i] = 0; m_lat[i] = 0; m_isr[i] = 0;
        if (i < N) begin m_en[i] = 0; m_trig[i] = 0; end
      end
      m_mode = 0; m_top = 0; m_last = 0; m_vec = N + 1;
    end else begin
      int s, t, nw;
      bit ln, rs, ed;
      s  = m_select();
      t  = eoi ? m_eoi_target() : -1;
      nw = -1;
      for (int i = 0; i <= N; i++) begin
        ln = (i == N) ? nmi : irq[i];
        rs = ln && !m_prev[i];
        ed = (i == N) ? 1'b1 : m_trig[i];
        if (rs && nw < 0) nw = i;
        m_lat[i]  = (rs && ed) || (m_lat[i] && !(ack && s == i));
        m_prev[i] = ln;
      end
      if (nw >= 0) m_last = nw;
      if (t >= 0) begin
        m_isr[t] = 0;
        if (t < N && m_mode == 2) m_top = (t + 1) % N;
      end
      if (ack) begin
        if (s >= 0) begin m_isr[s] = 1; m_vec = (s == N) ? 0 : s + 1; end
        else m_vec = N + 1;
      end
      for (int i = 0; i < N; i++) begin
        if (en_we)   m_en[i]   = en_wd[i];
        if (trig_we) m_trig[i] = trig_wd[i];
      end
      if (mode_we) m_mode = (mode_wd == 2'b01) ? 1 : (mode_wd == 2'b10) ? 2 : 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [8:0] e_isr;
      for (int i = 0; i <= N; i++) e_isr[i] = m_isr[i];
      chk("R5 model irq_o", {31'd0, irq_o}, {31'd0, m_select() >= 0});
      chk("R11 model vec_o", {28'd0, vec_o}, m_vec);
      chk("R12 model in_service_o", {23'd0, isr_o}, {23'd0, e_isr});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(posedge clk); #2; endtask
  task automatic do_ack(); ack = 1; tick(); ack = 0; endtask
  task automatic do_eoi(); eoi = 1; tick(); eoi = 0; endtask
  task automatic wr_en(logic [7:0] v); en_we = 1; en_wd = v; tick(); en_we = 0; endtask
  task automatic wr_trig(logic [7:0] v); trig_we = 1; trig_wd = v; tick(); trig_we = 0; endtask
  task automatic wr_mode(logic [1:0] v); mode_we = 1; mode_wd = v; tick(); mode_we = 0; endtask
  task automatic pulse_line(int i); irq[i] = 1; tick(); irq[i] = 0; endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    chk("R1 irq_o after reset", {31'd0, irq_o}, 0);
    chk("R1 vec_o after reset", {28'd0, vec_o}, 9);
    chk("R1 in_service after reset", {23'd0, isr_o}, 0);
    irq = 8'hff; tick(); tick();
    chk("R1 disabled lines silent", {31'd0, irq_o}, 0);
    irq = 8'h00; tick();

    wr_en(8'hff);
    irq[3] = 1; tick();
    chk("R3 level request seen", {31'd0, irq_o}, 1);
    do_ack();
    chk("R11 vector of line 3", {28'd0, vec_o}, 4);
    chk("R11 in-service line 3", {23'd0, isr_o}, 9'h008);
    chk("R6 own line masked", {31'd0, irq_o}, 0);
    do_eoi();
    chk("R4 level re-presented", {31'd0, irq_o}, 1);
    irq[3] = 0; tick();
    chk("R3 level drop withdraws", {31'd0, irq_o}, 0);
    irq[2] = 1; #5 irq[2] = 0; tick(); tick();
    chk("R3 sub-cycle pulse ignored", {31'd0, irq_o}, 0);

    wr_trig(8'h30);
    pulse_line(5); tick(); tick();
    chk("R2 edge latched", {31'd0, irq_o}, 1);
    do_ack();
    chk("R2 vector of line 5", {28'd0, vec_o}, 6);
    do_eoi();
    chk("R2 latch cleared by ack", {31'd0, irq_o}, 0);
    do_eoi();
    chk("R12 eoi with nothing in service", {23'd0, isr_o}, 0);

    irq[6] = 1; pulse_line(5);
    do_ack();
    chk("R5 line 5 beats line 6", {28'd0, vec_o}, 6);
    chk("R6 lower line masked", {31'd0, irq_o}, 0);
    pulse_line(4);
    chk("R6 higher line preempts", {31'd0, irq_o}, 1);
    do_ack();
    chk("R6 nested vector", {28'd0, vec_o}, 5);
    do_eoi();
    chk("R12 highest in-service cleared", {23'd0, isr_o}, 9'h020);
    do_eoi();
    do_ack();
    chk("R4 line 6 after both services", {28'd0, vec_o}, 7);
    do_eoi(); irq[6] = 0; tick();

    wr_en(8'hef);
    pulse_line(4); tick();
    chk("R10 disabled line held back", {31'd0, irq_o}, 0);
    wr_en(8'hff);
    chk("R10 latch kept over disable", {31'd0, irq_o}, 1);
    do_ack();
    chk("R10 vector of line 4", {28'd0, vec_o}, 5);
    do_eoi();

    do_ack();
    chk("R11 spurious vector", {28'd0, vec_o}, 9);
    chk("R11 spurious leaves state", {23'd0, isr_o}, 0);

    wr_en(8'h01);
    irq[0] = 1; tick();
    nmi = 1; tick(); nmi = 0;
    do_ack();
    chk("R7 nmi wins with vector 0", {28'd0, vec_o}, 0);
    chk("R7 nmi in service", {23'd0, isr_o}, 9'h100);
    chk("R7 nmi masks all", {31'd0, irq_o}, 0);
    do_eoi();
    do_ack();
    chk("R12 line 0 after nmi service", {28'd0, vec_o}, 1);
    do_eoi(); irq[0] = 0;
    wr_en(8'h00);
    nmi = 1; tick(); nmi = 0; tick();
    chk("R7 nmi ignores enables", {31'd0, irq_o}, 1);
    do_ack(); do_eoi();
    wr_en(8'hff);

    wr_mode(2'b01);
    pulse_line(4); tick();
    pulse_line(5); tick();
    do_ack();
    chk("R8 latest arrival wins", {28'd0, vec_o}, 6);
    chk("R8 single level masking", {31'd0, irq_o}, 0);
    do_eoi();
    do_ack();
    chk("R8 fallback to lowest line", {28'd0, vec_o}, 5);
    do_eoi();

    wr_mode(2'b10);
    irq[1] = 1; irq[2] = 1; tick();
    do_ack();
    chk("R9 line 1 first", {28'd0, vec_o}, 2);
    do_eoi();
    do_ack();
    chk("R9 line 2 after rotation", {28'd0, vec_o}, 3);
    do_eoi();
    do_ack();
    chk("R9 line 1 after second rotation", {28'd0, vec_o}, 2);
    do_eoi();

    wr_mode(2'b11);
    do_ack();
    chk("R5 reserved code is fixed", {28'd0, vec_o}, 2);
    do_eoi();
    irq = '0; tick(); tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule